// File: doc/BRIEF.md
# Jacobian Point Doubling Sequencer

This block doubles an elliptic-curve point given in Jacobian projective coordinates. It does no field arithmetic itself. It runs a fixed program of eighteen micro-operations. Each operation is a modular addition, subtraction or multiplication, and each is sent in turn to an attached modular ALU. Operands and intermediates are kept in a twelve-entry register file. A small ROM holds the program. Each ROM word names the operation, two source registers and one destination register.

The point (X, Y, Z) and the constant `delta` are taken in on a valid/ready stream. `delta` must equal the inverse of two modulo the field prime. The three doubled coordinates leave on a second valid/ready stream.
- Input back-pressure: `in_ready` is high only while the block is idle. An input word is taken on any cycle where `in_valid` and `in_ready` are both high.
- Output back-pressure: `out_valid` stays high, with the coordinates frozen, until `out_ready` is seen.

Halving is done by multiplying by `delta`. Doubling is done by adding a value to itself. A point at infinity (Z = 0) needs no branch: the output Z comes out zero from the arithmetic alone.

The ALU port is a plain start/done handshake. `alu_start` is a one-cycle pulse that carries the op code and both operand values. The ALU answers later with a one-cycle `alu_done` and the result. The operand values stay steady until that answer arrives.

Top module: `jac_dbl_seq`

## Requirements
- R1: After reset `in_ready` is 1, `out_valid` is 0 and `alu_start` is 0.
- R2: A transfer on the input stream (`in_valid` and `in_ready` both high on a rising edge) loads X, Y, Z and `delta`. `in_ready` then stays 0 until the result has been delivered.
- R3: Per input point the block issues exactly 18 operations in the fixed order below, with op codes 0 = add, 1 = sub, 2 = mul. Writing Zin = Z·Z, A = X−Zin, B = X+Zin, M = B·A, P = M+M, L = P+M, Y2 = Y+Y, the order is: Zin, A, B, M, P, L, Y2, Zout = Z·Y2, S = Y2·Y2, U = X·S, S2 = S·S, H = S2·delta, L2 = L·L, U2 = U+U, Xout = L2−U2, V = U−Xout, W = V·L, Yout = W−H.
- R4: Operations are issued one at a time. `alu_start` is a single-cycle pulse, and no new pulse appears before `alu_done` has answered the previous one.
- R5: From the `alu_start` pulse until `alu_done`, `alu_op`, `alu_a` and `alu_b` stay stable.
- R6: The halving step (operation 12, H) is a mul whose second operand is the loaded `delta`.
- R7: Each doubling (operations 5, 7 and 14: P, Y2, U2) is an add with both operands equal.
- R8: Each square (operations 1, 9, 11 and 13: Zin, S, S2, L2) is a mul with both operands taken from the same register, so `alu_a` equals `alu_b`.
- R9: When the result is presented, `out_x`, `out_y` and `out_z` are Xout, Yout and Zout as computed by the ALU's answers.
- R10: An input with Z = 0 runs the same 18 operations and gives `out_z` = 0.
- R11: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and all three coordinates hold. On the cycle after the output transfer, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input point valid |
| in_ready | output | 1 | Block idle and able to take a point |
| in_x | input | W | Input X |
| in_y | input | W | Input Y |
| in_z | input | W | Input Z |
| in_delta | input | W | Inverse of two modulo the prime |
| out_valid | output | 1 | Doubled point valid |
| out_ready | input | 1 | Consumer takes the doubled point |
| out_x | output | W | Doubled X |
| out_y | output | W | Doubled Y |
| out_z | output | W | Doubled Z |
| alu_start | output | 1 | One-cycle request to the ALU |
| alu_op | output | 2 | 0 add, 1 sub, 2 mul |
| alu_a | output | W | First operand |
| alu_b | output | W | Second operand |
| alu_done | input | 1 | One-cycle answer from the ALU |
| alu_result | input | W | ALU result, valid with `alu_done` |

## Verification
The bench stands in a behavioural modular ALU with a random answer latency. It compares every issued operation with a trace built from the formulas in R3. A wrong ROM entry, such as a swapped source or a wrong destination, shows up as a wrong operand at a named step. A design that started the next operation early, or let its operands drift, would break the trace or the one-at-a-time check at that step. Two corners get their own cases. A Z = 0 input catches a design that special-cases infinity or writes Zout from the wrong register. Values near q−1 catch reduction faults. Random output stalls catch a design that drops or changes the result under back-pressure.

// File: rtl/jdbl_pkg.sv
package jdbl_pkg;

  localparam int NREG  = 12;
  localparam int RIW   = 4;
  localparam int NSTEP = 18;
  localparam int STW   = $clog2(NSTEP);

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_MUL = 2'd2
  } alu_op_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_ISSUE,
    S_WAIT,
    S_DONE
  } seq_state_e;

  // register file map
  localparam logic [RIW-1:0] RG_X  = 4'd0;
  localparam logic [RIW-1:0] RG_Y  = 4'd1;
  localparam logic [RIW-1:0] RG_Z  = 4'd2;
  localparam logic [RIW-1:0] RG_D  = 4'd3;
  localparam logic [RIW-1:0] RG_T1 = 4'd4;
  localparam logic [RIW-1:0] RG_T2 = 4'd5;
  localparam logic [RIW-1:0] RG_T3 = 4'd6;
  localparam logic [RIW-1:0] RG_T4 = 4'd7;
  localparam logic [RIW-1:0] RG_T5 = 4'd8;
  localparam logic [RIW-1:0] RG_OX = 4'd9;
  localparam logic [RIW-1:0] RG_OY = 4'd10;
  localparam logic [RIW-1:0] RG_OZ = 4'd11;

  typedef struct packed {
    alu_op_e        op;
    logic [RIW-1:0] sa;
    logic [RIW-1:0] sb;
    logic [RIW-1:0] dst;
  } uop_t;

  function automatic uop_t mk(alu_op_e o, logic [RIW-1:0] a,
                              logic [RIW-1:0] b, logic [RIW-1:0] d);
    uop_t u;
    u.op = o; u.sa = a; u.sb = b; u.dst = d;
    return u;
  endfunction

  function automatic uop_t uop_at(logic [STW-1:0] i);
    case (i)
      5'd0:    return mk(OP_MUL, RG_Z,  RG_Z,  RG_T1);
      5'd1:    return mk(OP_SUB, RG_X,  RG_T1, RG_T2);
      5'd2:    return mk(OP_ADD, RG_X,  RG_T1, RG_T3);
      5'd3:    return mk(OP_MUL, RG_T3, RG_T2, RG_T4);
      5'd4:    return mk(OP_ADD, RG_T4, RG_T4, RG_T1);
      5'd5:    return mk(OP_ADD, RG_T1, RG_T4, RG_T2);
      5'd6:    return mk(OP_ADD, RG_Y,  RG_Y,  RG_OY);
      5'd7:    return mk(OP_MUL, RG_Z,  RG_OY, RG_OZ);
      5'd8:    return mk(OP_MUL, RG_OY, RG_OY, RG_T1);
      5'd9:    return mk(OP_MUL, RG_X,  RG_T1, RG_T3);
      5'd10:   return mk(OP_MUL, RG_T1, RG_T1, RG_T4);
      5'd11:   return mk(OP_MUL, RG_T4, RG_D,  RG_T5);
      5'd12:   return mk(OP_MUL, RG_T2, RG_T2, RG_T4);
      5'd13:   return mk(OP_ADD, RG_T3, RG_T3, RG_T1);
      5'd14:   return mk(OP_SUB, RG_T4, RG_T1, RG_OX);
      5'd15:   return mk(OP_SUB, RG_T3, RG_OX, RG_T1);
      5'd16:   return mk(OP_MUL, RG_T1, RG_T2, RG_T3);
      default: return mk(OP_SUB, RG_T3, RG_T5, RG_OY);
    endcase
  endfunction

endpackage

// File: rtl/jdbl_rom.sv
module jdbl_rom
  import jdbl_pkg::*;
(
  input  logic [STW-1:0] step,
  output uop_t           uop
);
  always_comb uop = uop_at(step);
endmodule

// File: rtl/jdbl_regfile.sv
module jdbl_regfile
  import jdbl_pkg::*;
#(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_en,
  input  logic [W-1:0]   ld_x,
  input  logic [W-1:0]   ld_y,
  input  logic [W-1:0]   ld_z,
  input  logic [W-1:0]   ld_d,
  input  logic           wr_en,
  input  logic [RIW-1:0] wr_idx,
  input  logic [W-1:0]   wr_data,
  input  logic [RIW-1:0] rd_a_idx,
  input  logic [RIW-1:0] rd_b_idx,
  output logic [W-1:0]   rd_a,
  output logic [W-1:0]   rd_b,
  output logic [W-1:0]   q_x,
  output logic [W-1:0]   q_y,
  output logic [W-1:0]   q_z
);
  logic [W-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic         ld_hit;
    logic [W-1:0] ld_val;
    if (g == int'(RG_X)) begin : g_x
      assign ld_hit = 1'b1; assign ld_val = ld_x;
    end else if (g == int'(RG_Y)) begin : g_y
      assign ld_hit = 1'b1; assign ld_val = ld_y;
    end else if (g == int'(RG_Z)) begin : g_z
      assign ld_hit = 1'b1; assign ld_val = ld_z;
    end else if (g == int'(RG_D)) begin : g_d
      assign ld_hit = 1'b1; assign ld_val = ld_d;
    end else begin : g_tmp
      assign ld_hit = 1'b0; assign ld_val = '0;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)
        regs[g] <= '0;
      else if (load_en && ld_hit)
        regs[g] <= ld_val;
      else if (wr_en && (wr_idx == RIW'(g)))
        regs[g] <= wr_data;
    end
  end

  always_comb begin
    rd_a = (int'(rd_a_idx) < NREG) ? regs[rd_a_idx] : '0;
    rd_b = (int'(rd_b_idx) < NREG) ? regs[rd_b_idx] : '0;
  end

  assign q_x = regs[RG_OX];
  assign q_y = regs[RG_OY];
  assign q_z = regs[RG_OZ];

  // R2: loading never overlaps a result write
  assert_no_load_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |-> !wr_en);
endmodule

// File: rtl/jdbl_ctrl.sv
module jdbl_ctrl
  import jdbl_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  output logic           load_en,
  input  logic           out_ready,
  output logic           out_valid,
  output logic           alu_start,
  input  logic           alu_done,
  output logic           wr_en,
  output logic           op_pending,
  output logic [STW-1:0] step
);
  localparam logic [STW-1:0] LAST = STW'(NSTEP - 1);

  seq_state_e st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      step <= '0;
    end else begin
      case (st)
        S_IDLE: if (in_valid) begin
          st   <= S_ISSUE;
          step <= '0;
        end
        S_ISSUE: st <= S_WAIT;
        S_WAIT: if (alu_done) begin
          if (step == LAST) st <= S_DONE;
          else begin
            step <= step + 1'b1;
            st   <= S_ISSUE;
          end
        end
        default: if (out_ready) st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    in_ready   = (st == S_IDLE);
    load_en    = in_valid && in_ready;
    alu_start  = (st == S_ISSUE);
    op_pending = (st == S_WAIT);
    wr_en      = op_pending && alu_done;
    out_valid  = (st == S_DONE);
  end

  // R4: single-cycle start pulse
  assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    alu_start |=> !alu_start);
  // R4: no new start while an answer is outstanding
  assert_one_outstanding_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_pending && !alu_done) |=> !alu_start);
  // R2: busy after accept
  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> !in_ready);
  // R11: back-pressure holds valid
  assert_out_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);
  assert_handshake_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({in_ready, alu_start, out_valid}));
endmodule

// File: rtl/jac_dbl_seq.sv
module jac_dbl_seq
  import jdbl_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_x,
  input  logic [W-1:0] in_y,
  input  logic [W-1:0] in_z,
  input  logic [W-1:0] in_delta,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_x,
  output logic [W-1:0] out_y,
  output logic [W-1:0] out_z,
  output logic         alu_start,
  output logic [1:0]   alu_op,
  output logic [W-1:0] alu_a,
  output logic [W-1:0] alu_b,
  input  logic         alu_done,
  input  logic [W-1:0] alu_result
);
  logic           load_en, wr_en, op_pending;
  logic [STW-1:0] step;
  uop_t           uop;

  jdbl_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .load_en(load_en),
    .out_ready(out_ready), .out_valid(out_valid),
    .alu_start(alu_start), .alu_done(alu_done),
    .wr_en(wr_en), .op_pending(op_pending), .step(step)
  );

  jdbl_rom u_rom (.step(step), .uop(uop));

  jdbl_regfile #(.W(W)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .load_en(load_en), .ld_x(in_x), .ld_y(in_y), .ld_z(in_z), .ld_d(in_delta),
    .wr_en(wr_en), .wr_idx(uop.dst), .wr_data(alu_result),
    .rd_a_idx(uop.sa), .rd_b_idx(uop.sb),
    .rd_a(alu_a), .rd_b(alu_b),
    .q_x(out_x), .q_y(out_y), .q_z(out_z)
  );

  assign alu_op = uop.op;

  // answers counted per point, for the program-length check
  logic [STW:0] done_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)        done_cnt <= '0;
    else if (load_en)  done_cnt <= '0;
    else if (wr_en)    done_cnt <= done_cnt + 1'b1;
  end

  // R3: exactly NSTEP answers before the result appears
  assert_program_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (done_cnt == (STW+1)'(NSTEP)));
  // R5: request fields steady while waiting
  assert_operands_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_pending && !alu_done) |=> ($stable(alu_a) && $stable(alu_b) && $stable(alu_op)));
  // R11: coordinates frozen under back-pressure
  assert_out_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> ($stable(out_x) && $stable(out_y) && $stable(out_z)));
endmodule

// File: tb/tb_jac_dbl_seq.sv
module tb_jac_dbl_seq;
  localparam int W       = 16;
  localparam int CLK_PER = 10;
  localparam int unsigned Q     = 65521;
  localparam int unsigned DELTA = (Q + 1) / 2;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 0, alu_done = 0;
  logic [W-1:0] in_x = 0, in_y = 0, in_z = 0, in_delta = 0, alu_result = 0;
  logic in_ready, out_valid, alu_start;
  logic [1:0] alu_op;
  logic [W-1:0] out_x, out_y, out_z, alu_a, alu_b;

  jac_dbl_seq #(.W(W)) dut (.*);

  always #(CLK_PER/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, string what, int unsigned act, int unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int unsigned madd(int unsigned a, int unsigned b);
    return (a + b) % Q;
  endfunction
  function automatic int unsigned msub(int unsigned a, int unsigned b);
    return (a + Q - b) % Q;
  endfunction
  function automatic int unsigned mmul(int unsigned a, int unsigned b);
    return int'((longint'(a) * longint'(b)) % Q);
  endfunction

  // expected trace
  int unsigned e_op [18], e_a [18], e_b [18];
  int unsigned e_x, e_y, e_z;

  task automatic rec(int i, int unsigned o, int unsigned a, int unsigned b, output int unsigned r);
    e_op[i] = o; e_a[i] = a; e_b[i] = b;
    r = (o == 0) ? madd(a, b) : (o == 1) ? msub(a, b) : mmul(a, b);
  endtask

  task automatic build(int unsigned x, int unsigned y, int unsigned z, int unsigned d);
    int unsigned zin, am, bp, m, p, l, y2, zo, s, u, s2, h, l2, u2, xo, v, w, yo;
    rec(0, 2, z, z, zin);     rec(1, 1, x, zin, am);   rec(2, 0, x, zin, bp);
    rec(3, 2, bp, am, m);     rec(4, 0, m, m, p);      rec(5, 0, p, m, l);
    rec(6, 0, y, y, y2);      rec(7, 2, z, y2, zo);    rec(8, 2, y2, y2, s);
    rec(9, 2, x, s, u);       rec(10, 2, s, s, s2);    rec(11, 2, s2, d, h);
    rec(12, 2, l, l, l2);     rec(13, 0, u, u, u2);    rec(14, 1, l2, u2, xo);
    rec(15, 1, u, xo, v);     rec(16, 2, v, l, w);     rec(17, 1, w, h, yo);
    e_x = xo; e_y = yo; e_z = zo;
  endtask

  function automatic string step_req(int i);
    if (i == 11) return "R6";
    if (i == 4 || i == 6 || i == 13) return "R7";
    if (i == 0 || i == 8 || i == 10 || i == 12) return "R8";
    return "R3";
  endfunction

  // behavioural ALU with random latency, sampled at negedge
  int pend = 0, nstart = 0;
  int unsigned pres = 0, cur_d = 0;
  logic [1:0] hop; logic [W-1:0] ha, hb;
  always @(negedge clk) begin
    if (rst_n && pend > 0) begin
      chk(alu_op == hop && alu_a == ha && alu_b == hb, "R5", "request held", alu_a, ha);
    end
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin alu_done = 1; alu_result = W'(pres); end
      else alu_done = 0;
    end else alu_done = 0;
    if (rst_n && alu_start) begin
      chk(pend == 0 && !alu_done, "R4", "start while outstanding", pend, 0);
      if (nstart < 18) begin
        string rq = step_req(nstart);
        chk(alu_op == e_op[nstart], rq, $sformatf("op at step %0d", nstart), alu_op, e_op[nstart]);
        chk(alu_a == e_a[nstart], rq, $sformatf("a at step %0d", nstart), alu_a, e_a[nstart]);
        chk(alu_b == e_b[nstart], rq, $sformatf("b at step %0d", nstart), alu_b, e_b[nstart]);
        if (nstart == 11) chk(alu_b == cur_d, "R6", "halving uses delta", alu_b, cur_d);
        if (e_a[nstart] == e_b[nstart] && e_op[nstart] != 1)
          chk(alu_a == alu_b, rq, "equal operands", alu_a, alu_b);
      end
      nstart++;
      hop = alu_op; ha = alu_a; hb = alu_b;
      pres = (alu_op == 0) ? madd(alu_a, alu_b) : (alu_op == 1) ? msub(alu_a, alu_b) : mmul(alu_a, alu_b);
      pend = 1 + int'($urandom % 4);
    end
  end

  task automatic run_point(int unsigned x, int unsigned y, int unsigned z, string tag);
    int stall;
    build(x, y, z, DELTA);
    cur_d = DELTA; nstart = 0;
    @(negedge clk);
    chk(in_ready, "R2", {tag, " idle before load"}, in_ready, 1);
    in_valid = 1; in_x = W'(x); in_y = W'(y); in_z = W'(z); in_delta = W'(DELTA);
    @(negedge clk);
    in_valid = 0; in_x = '0; in_y = '0;
    chk(!in_ready, "R2", {tag, " busy after load"}, in_ready, 0);
    while (!out_valid) @(negedge clk);
    chk(nstart == 18, "R3", {tag, " op count"}, nstart, 18);
    chk(out_x == e_x, "R9", {tag, " out_x"}, out_x, e_x);
    chk(out_y == e_y, "R9", {tag, " out_y"}, out_y, e_y);
    chk(out_z == e_z, z == 0 ? "R10" : "R9", {tag, " out_z"}, out_z, e_z);
    stall = int'($urandom % 4);
    repeat (stall) begin
      @(negedge clk);
      chk(out_valid && out_x == e_x && out_y == e_y && out_z == e_z, "R11",
          {tag, " held under stall"}, out_x, e_x);
    end
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
    chk(!out_valid && in_ready, "R11", {tag, " back to idle"}, {out_valid, in_ready}, 1);
  endtask

  initial begin
    void'($urandom(32'h5eed1));
    repeat (3) @(negedge clk);
    chk(in_ready == 1, "R1", "reset in_ready", in_ready, 1);
    chk(out_valid == 0, "R1", "reset out_valid", out_valid, 0);
    chk(alu_start == 0, "R1", "reset alu_start", alu_start, 0);
    rst_n = 1;
    run_point(1234, 5678, 1, "affine");
    run_point(1234, 5678, 0, "R10 infinity");
    run_point(0, 17, 99, "x zero");
    run_point(Q - 1, Q - 1, Q - 1, "top values");
    run_point(7, 0, 3, "y zero");
    for (int i = 0; i < 12; i++)
      run_point($urandom % Q, $urandom % Q, $urandom % Q, "random");
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL R3 watchdog expired: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule